// File: doc/BRIEF.md
# Coherent 64-bit Time Base Reader

This block keeps a free-running 64-bit time count that advances by one on every clock cycle in which an external tick enable is high. A 32-bit bus master can look at either half of the count through a combinational read port. It can also overwrite either half through a synchronous write port.

A hardware snapshot sequencer returns the whole 64-bit value without tearing. When it is asked for a snapshot, it samples the upper half, then the lower half, then the upper half again, each in its own cycle. The count may advance between these samples. A pairing rule then picks which upper sample belongs with the lower sample, so a carry out of the low word between samples never yields a value that is off by 2^32. The joined result appears with a one-cycle valid strobe. A busy flag covers the sampling window.

Top module: `timebase_reader`

## Requirements
- R1: While reset is active and after it is released, the count is zero, `snap_busy_o` and `snap_valid_o` are low, and `snap_data_o` is zero.
- R2: At each clock edge where `tick_i` is high and no write occurs, the 64-bit count increases by exactly one, carrying from bit 31 into bit 32 and wrapping from all-ones to zero. Without a tick it holds.
- R3: `rd_data_o` shows the upper half when `rd_hi_sel_i` is high, shows the lower half when only `rd_lo_sel_i` is high, and is zero when neither select is high. It follows the count in the same cycle.
- R4: When `wr_en_i` is high, `wr_data_i` replaces the upper half if `wr_hi_i` is 1, or the lower half if `wr_hi_i` is 0. The other half is unchanged, no carry is produced, and a tick in that same cycle is dropped.
- R5: A request on `snap_req_i` is accepted only while the sequencer is idle. The sequencer takes the upper half in the first cycle after acceptance, the lower half in the second, and the upper half again in the third.
- R6: If the two upper samples match, the result is that upper value joined with the lower sample.
- R7: If the two upper samples differ, the lower sample is joined with the first upper sample when its bit 31 is 1, and with the second upper sample when bit 31 is 0.
- R8: The snapshot equals the count held during the lower-sample cycle. This holds when the low word wraps before, between or after any of the three samples, and when the full 64-bit count wraps.
- R9: `snap_busy_o` is high for exactly the three sampling cycles. `snap_valid_o` pulses for one cycle immediately after them. A request held or raised while busy starts no extra snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count advance enable |
| rd_lo_sel_i | input | 1 | Select lower half on read port |
| rd_hi_sel_i | input | 1 | Select upper half on read port (wins over lower) |
| rd_data_o | output | 32 | Selected half of the count |
| wr_en_i | input | 1 | Write strobe for one half |
| wr_hi_i | input | 1 | Write target: 1 upper half, 0 lower half |
| wr_data_i | input | 32 | Value written into the chosen half |
| snap_req_i | input | 1 | Request a coherent 64-bit snapshot |
| snap_busy_o | output | 1 | Sampling sequence in progress |
| snap_valid_o | output | 1 | One-cycle strobe marking a fresh snapshot |
| snap_data_o | output | 64 | Coherent 64-bit snapshot |

## Verification
Snapshots are taken from preloads just below a low-word wrap. The tick pattern is varied so that the wrap falls before the first upper sample, between the first upper and lower samples, or between the lower and second upper samples. Each placement exercises a different branch of the pairing rule. Other cases use no ticks at all, a low word that crosses bit 31 without wrapping, and a full 64-bit wrap, which separate the equal-upper path from the bit-31 test and show that the result is taken modulo 2^64. Directed cases hold the request high through the busy window and put a write and a tick in the same cycle, which shows whether extra snapshots start and whether the dropped tick or a stray carry leaks into the other half.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_HI_FIRST  = 2'd1,
    SEQ_LO        = 2'd2,
    SEQ_HI_SECOND = 2'd3
  } seq_state_e;

endpackage

// File: rtl/tbr_counter.sv
module tbr_counter #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic                  wr_hi_i,
  input  logic [HALF_W-1:0]     wr_data_i,
  output logic [2*HALF_W-1:0]   count_o
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cnt_q;
  logic [FULL_W-1:0] cnt_d;

  // Writes win over ticks; a write never carries into the other half.
  always_comb begin
    cnt_d = cnt_q;
    if (wr_en_i) begin
      if (wr_hi_i) begin
        cnt_d[FULL_W-1:HALF_W] = wr_data_i;
      end else begin
        cnt_d[HALF_W-1:0] = wr_data_i;
      end
    end else if (tick_i) begin
      cnt_d = cnt_q + FULL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_en_i || tick_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/tbr_pair.sv
module tbr_pair #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0]   hi_first_i,
  input  logic [HALF_W-1:0]   lo_i,
  input  logic [HALF_W-1:0]   hi_second_i,
  output logic [2*HALF_W-1:0] joined_o
);

  // A set top bit of the low sample means it was taken before the wrap,
  // so it belongs with the earlier upper sample.
  always_comb begin
    if (hi_first_i == hi_second_i) begin
      joined_o = {hi_first_i, lo_i};
    end else if (lo_i[HALF_W-1]) begin
      joined_o = {hi_first_i, lo_i};
    end else begin
      joined_o = {hi_second_i, lo_i};
    end
  end

endmodule

// File: rtl/tbr_seq.sv
module tbr_seq
  import tbr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [HALF_W-1:0]     cnt_lo_i,
  input  logic [HALF_W-1:0]     cnt_hi_i,
  input  logic [2*HALF_W-1:0]   joined_i,
  output logic [HALF_W-1:0]     hi_first_o,
  output logic [HALF_W-1:0]     lo_o,
  output logic                  busy_o,
  output logic                  valid_o,
  output logic [2*HALF_W-1:0]   data_o
);

  localparam int FULL_W = 2 * HALF_W;

  seq_state_e        state_q, state_d;
  logic [HALF_W-1:0] hi_first_q;
  logic [HALF_W-1:0] lo_q;
  logic [FULL_W-1:0] data_q;
  logic              valid_q;

  logic cap_hi_first;
  logic cap_lo;
  logic cap_result;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:      if (req_i) state_d = SEQ_HI_FIRST;
      SEQ_HI_FIRST:  state_d = SEQ_LO;
      SEQ_LO:        state_d = SEQ_HI_SECOND;
      SEQ_HI_SECOND: state_d = SEQ_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  assign cap_hi_first = (state_q == SEQ_HI_FIRST);
  assign cap_lo       = (state_q == SEQ_LO);
  assign cap_result   = (state_q == SEQ_HI_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= cap_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_first_q <= '0;
    end else if (cap_hi_first) begin
      hi_first_q <= cnt_hi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_lo) begin
      lo_q <= cnt_lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_result) begin
      data_q <= joined_i;
    end
  end

  assign hi_first_o = hi_first_q;
  assign lo_o       = lo_q;
  assign busy_o     = (state_q != SEQ_IDLE);
  assign valid_o    = valid_q;
  assign data_o     = data_q;

endmodule

// File: rtl/timebase_reader.sv
module timebase_reader #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  rd_lo_sel_i,
  input  logic                  rd_hi_sel_i,
  output logic [HALF_W-1:0]     rd_data_o,
  input  logic                  wr_en_i,
  input  logic                  wr_hi_i,
  input  logic [HALF_W-1:0]     wr_data_i,
  input  logic                  snap_req_i,
  output logic                  snap_busy_o,
  output logic                  snap_valid_o,
  output logic [2*HALF_W-1:0]   snap_data_o
);

  localparam int FULL_W    = 2 * HALF_W;
  localparam int RST_DEPTH = 2;

  logic [RST_DEPTH-1:0] rst_pipe_q;
  logic                 rst_sync_n;
  logic [FULL_W-1:0]    count_w;
  logic [HALF_W-1:0]    hi_first_w;
  logic [HALF_W-1:0]    lo_w;
  logic [FULL_W-1:0]    joined_w;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_DEPTH-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[RST_DEPTH-1];

  tbr_counter #(.HALF_W(HALF_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_w)
  );

  tbr_pair #(.HALF_W(HALF_W)) u_pair (
    .hi_first_i  (hi_first_w),
    .lo_i        (lo_w),
    .hi_second_i (count_w[FULL_W-1:HALF_W]),
    .joined_o    (joined_w)
  );

  tbr_seq #(.HALF_W(HALF_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (snap_req_i),
    .cnt_lo_i   (count_w[HALF_W-1:0]),
    .cnt_hi_i   (count_w[FULL_W-1:HALF_W]),
    .joined_i   (joined_w),
    .hi_first_o (hi_first_w),
    .lo_o       (lo_w),
    .busy_o     (snap_busy_o),
    .valid_o    (snap_valid_o),
    .data_o     (snap_data_o)
  );

  always_comb begin
    if (rd_hi_sel_i) begin
      rd_data_o = count_w[FULL_W-1:HALF_W];
    end else if (rd_lo_sel_i) begin
      rd_data_o = count_w[HALF_W-1:0];
    end else begin
      rd_data_o = '0;
    end
  end

endmodule

// File: rtl/tbr_chk.sv
module tbr_chk #(
  parameter int HALF_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_i,
  input logic                  wr_en_i,
  input logic                  wr_hi_i,
  input logic [HALF_W-1:0]     wr_data_i,
  input logic                  snap_req_i,
  input logic                  snap_busy_o,
  input logic                  snap_valid_o,
  input logic [2*HALF_W-1:0]   snap_data_o,
  input logic [2*HALF_W-1:0]   count_w
);

  localparam int FULL_W = 2 * HALF_W;

  // R2
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i) |=> (count_w == $past(count_w) + FULL_W'(1)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(count_w));

  // R4
  wr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_hi_i) |=> (count_w[FULL_W-1:HALF_W] == $past(wr_data_i))
                           && (count_w[HALF_W-1:0] == $past(count_w[HALF_W-1:0])));

  // R4
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_hi_i) |=> (count_w[HALF_W-1:0] == $past(wr_data_i))
                            && (count_w[FULL_W-1:HALF_W] == $past(count_w[FULL_W-1:HALF_W])));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req_i && !snap_busy_o) |=> snap_busy_o);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid_o |=> !snap_valid_o);

  // R9
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid_o |-> (!snap_busy_o && $past(snap_busy_o)));

  // R8 (holds while no write lands inside the sampling window)
  coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid_o && !$past(wr_en_i) && !$past(wr_en_i, 2))
      |-> (snap_data_o == $past(count_w, 2)));

endmodule

bind timebase_reader tbr_chk #(.HALF_W(HALF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .wr_hi_i      (wr_hi_i),
  .wr_data_i    (wr_data_i),
  .snap_req_i   (snap_req_i),
  .snap_busy_o  (snap_busy_o),
  .snap_valid_o (snap_valid_o),
  .snap_data_o  (snap_data_o),
  .count_w      (count_w)
);

// File: tb/timebase_reader_bench.sv
module timebase_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {preload[63:0], tick pattern[3:0]}; tick bit k drives cycle k of the snapshot
  localparam logic [67:0] VEC_TABLE [NVEC] = '{
    {64'h0000_0000_FFFF_FFFE, 4'b1111},
    {64'h0000_0000_FFFF_FFFD, 4'b1111},
    {64'h0000_0000_FFFF_FFFF, 4'b1111},
    {64'h0000_0007_1234_5678, 4'b0000},
    {64'h1234_5678_FFFF_FFF0, 4'b0101},
    {64'hFFFF_FFFF_FFFF_FFFE, 4'b1111},
    {64'h0000_00AB_7FFF_FFFF, 4'b1111},
    {64'h0000_0000_FFFF_FFFE, 4'b0110}
  };

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        rd_lo_sel_i;
  logic        rd_hi_sel_i;
  logic [31:0] rd_data_o;
  logic        wr_en_i;
  logic        wr_hi_i;
  logic [31:0] wr_data_i;
  logic        snap_req_i;
  logic        snap_busy_o;
  logic        snap_valid_o;
  logic [63:0] snap_data_o;

  int checks;
  int errors;

  timebase_reader u_timebase_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .rd_lo_sel_i  (rd_lo_sel_i),
    .rd_hi_sel_i  (rd_hi_sel_i),
    .rd_data_o    (rd_data_o),
    .wr_en_i      (wr_en_i),
    .wr_hi_i      (wr_hi_i),
    .wr_data_i    (wr_data_i),
    .snap_req_i   (snap_req_i),
    .snap_busy_o  (snap_busy_o),
    .snap_valid_o (snap_valid_o),
    .snap_data_o  (snap_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_count(output logic [63:0] val);
    rd_hi_sel_i = 1'b1; rd_lo_sel_i = 1'b0;
    #1;
    val[63:32] = rd_data_o;
    rd_hi_sel_i = 1'b0; rd_lo_sel_i = 1'b1;
    #1;
    val[31:0] = rd_data_o;
    rd_lo_sel_i = 1'b0;
  endtask

  task automatic write_half(input logic hi, input logic [31:0] data, input logic tk);
    wr_en_i = 1'b1; wr_hi_i = hi; wr_data_i = data; tick_i = tk;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic run_snap(input logic [63:0] pre, input logic [3:0] tk,
                          input bit hold_req, input string tag);
    logic [63:0] cnt;
    logic [63:0] exp_snap;
    logic [63:0] exp_end;
    write_half(1'b1, pre[63:32], 1'b0);
    write_half(1'b0, pre[31:0], 1'b0);
    exp_snap = pre + 64'(tk[0]) + 64'(tk[1]);
    exp_end  = pre + 64'($countones(tk));
    snap_req_i = 1'b1; tick_i = tk[0];
    @(negedge clk);
    if (!hold_req) snap_req_i = 1'b0;
    tick_i = tk[1];
    check({tag, " R9 busy in first sample cycle"}, 64'(snap_busy_o), 64'd1);
    @(negedge clk);
    tick_i = tk[2];
    @(negedge clk);
    tick_i = tk[3];
    @(negedge clk);
    snap_req_i = 1'b0; tick_i = 1'b0;
    check({tag, " R9 valid strobe"}, 64'(snap_valid_o), 64'd1);
    check({tag, " R9 busy dropped"}, 64'(snap_busy_o), 64'd0);
    check({tag, " R8 R6 R7 coherent snapshot"}, snap_data_o, exp_snap);
    @(negedge clk);
    check({tag, " R9 valid single cycle"}, 64'(snap_valid_o), 64'd0);
    check({tag, " R5 no extra snapshot"}, 64'(snap_busy_o), 64'd0);
    read_count(cnt);
    check({tag, " R2 count after ticks"}, cnt, exp_end);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] cnt;
    checks = 0; errors = 0;
    rst_n = 1'b0; tick_i = 1'b0; rd_lo_sel_i = 1'b0; rd_hi_sel_i = 1'b0;
    wr_en_i = 1'b0; wr_hi_i = 1'b0; wr_data_i = '0; snap_req_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(snap_busy_o), 64'd0);
    check("R1 valid in reset", 64'(snap_valid_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 snapshot data after reset", snap_data_o, 64'd0);
    read_count(cnt);
    check("R1 count after reset", cnt, 64'd0);

    // R2: ticks on some cycles only
    for (int i = 0; i < 6; i++) begin
      tick_i = (i == 0 || i == 2 || i == 3);
      @(negedge clk);
    end
    tick_i = 1'b0;
    read_count(cnt);
    check("R2 three ticks counted", cnt, 64'd3);

    // R4: write upper half with a tick in the same cycle; tick dropped
    write_half(1'b1, 32'h0000_0005, 1'b1);
    read_count(cnt);
    check("R4 upper write, tick dropped", cnt, 64'h0000_0005_0000_0003);
    write_half(1'b0, 32'hFFFF_FFFF, 1'b0);
    read_count(cnt);
    check("R4 lower write no carry", cnt, 64'h0000_0005_FFFF_FFFF);

    // R3: select priority and idle value
    rd_hi_sel_i = 1'b1; rd_lo_sel_i = 1'b1;
    #1;
    check("R3 both selects give upper", 64'(rd_data_o), 64'h5);
    rd_hi_sel_i = 1'b0; rd_lo_sel_i = 1'b0;
    #1;
    check("R3 no select gives zero", 64'(rd_data_o), 64'h0);

    // R2: counting carries from low into high
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    read_count(cnt);
    check("R2 carry into upper half", cnt, 64'h0000_0006_0000_0000);

    for (int v = 0; v < NVEC; v++) begin
      run_snap(VEC_TABLE[v][67:4], VEC_TABLE[v][3:0], 1'b0, $sformatf("vec%0d", v));
    end

    // R5 / R9: request held through the busy window
    run_snap(64'h0000_0002_FFFF_FFFE, 4'b1111, 1'b1, "held request");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule